// File: doc/BRIEF.md
# Burst-of-two separate-port SRAM

This block is a synchronous memory with a read data port and a write data port that are kept apart. Every access moves two words, one per clock phase. The block runs on a single clock at twice the access rate. An internal phase bit alternates between a first phase and a second phase. The first clock edge after reset is released is always a first-phase edge.

Both ports share one address bus. On the first phase the bus carries the read address. On the second phase it carries the write address. Write data comes in as two beats, one per phase, and each beat has its own active-low byte-lane enables. Inside, the array is split into two banks, one for each beat, so a burst address selects a word pair.

A read that is issued in the same access as a write to the same address returns the incoming write data, merged lane by lane over the old contents. Read data comes out after a fixed latency that a parameter sets. Each beat is marked valid, and a flag picks out the second beat.

Top module: `burst2_sram`

## Requirements
- R1: While `rst` is high and on the cycle after it, `rd_valid` is low. No read output appears from a read whose output was still pending when reset was asserted.
- R2: A read takes `rd_sel_n` low and the read address on `addr` at a first-phase edge. Beat 0 is shown on `rdata` with `rd_valid`=1 and `rd_last`=0 exactly 2+2*EXTRA_LAT clock edges after that edge. Beat 1 follows on the next cycle with `rd_valid`=1 and `rd_last`=1.
- R3: A write takes `wr_sel_n` low, the first data beat and its enables at a first-phase edge. It takes the write address, the second beat and its enables at the following second-phase edge. The burst is stored so that later reads of that address return beat 0 and beat 1.
- R4: `wbe_n[l]` low enables byte lane l, which is bits [LW*l+LW-1 : LW*l] with LW = DW/LANES (9 bits at the default). The enables apply to each beat on its own. Lanes whose enable is high keep their old contents. An all-high mask writes nothing.
- R5: A read and a write in the same access can share an address. In that case the read returns the write data for the enabled lanes of each beat and the old contents for the rest.
- R6: When `wr_sel_n` is high at the first-phase edge, that access writes nothing, whatever is on `wdata`, `wbe_n` and `addr`.
- R7: When `rd_sel_n` is high at the first-phase edge, that access produces no `rd_valid` beat.
- R8: A new read, write or both can be issued on every access (two clock cycles), with no idle access needed between bursts.
- R9: `addr` is used as the read address on the first phase and as the write address on the second phase. Different values on the two phases address different words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the access rate; every rising edge is one phase |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel_n | input | 1 | Active-low read select, sampled on first-phase edges |
| wr_sel_n | input | 1 | Active-low write select, sampled on first-phase edges |
| addr | input | AW | Shared address: read address on phase one, write address on phase two |
| wdata | input | DW | Write data, one beat per phase |
| wbe_n | input | LANES | Active-low byte-lane write enables, one set per beat |
| rdata | output | DW | Read data beat |
| rd_valid | output | 1 | Read beat valid |
| rd_last | output | 1 | High on the second beat of a read burst |

## Verification
The bench sends reads and writes to the same address in one access, using both full and partial lane masks. A design that forwarded nothing, or ignored the masks while forwarding, would return stale or over-written lanes. It also reads an address on the first phase while writing a different one on the second phase. A design that used a single address for both ports would corrupt the wrong word.

Other accesses leave some lanes or the whole write unselected while the data bus carries noise. Any leakage would then show up in a later read. Each beat is checked at its exact clock, so an off-by-one latency or swapped beats fail. A reset taken while a read is in flight must suppress that read's output, and a design that let it through would produce an unexpected valid beat.

// File: rtl/b2s_pkg.sv
`timescale 1ns/1ps
package b2s_pkg;
  // Which half of an access the current clock edge belongs to.
  typedef enum logic {
    PH_RISE = 1'b0,
    PH_FALL = 1'b1
  } phase_e;
endpackage

// File: rtl/b2s_bank.sv
`timescale 1ns/1ps
// One beat bank: a memory per byte lane so each lane has its own write enable.
module b2s_bank #(
  parameter int DW    = 36,
  parameter int LANES = 4,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] wmask,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  localparam int LW    = DW / LANES;
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] q;

    always_ff @(posedge clk) begin
      if (we && wmask[l]) mem[waddr] <= wdata[l*LW +: LW];
      if (re)             q          <= mem[raddr];
    end

    assign rdata[l*LW +: LW] = q;
  end
endmodule

// File: rtl/b2s_outpipe.sv
`timescale 1ns/1ps
// Extra output delay stages, count chosen by parameter.
module b2s_outpipe #(
  parameter int DW     = 36,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_val,
  input  logic          in_last,
  input  logic [DW-1:0] in_data,
  output logic          out_val,
  output logic          out_last,
  output logic [DW-1:0] out_data
);
  if (STAGES == 0) begin : g_bypass
    assign out_val  = in_val;
    assign out_last = in_last;
    assign out_data = in_data;
  end else begin : g_pipe
    logic [STAGES-1:0] v;
    logic [STAGES-1:0] lst;
    logic [DW-1:0]     d [STAGES];

    always_ff @(posedge clk) begin
      if (rst) begin
        v   <= '0;
        lst <= '0;
      end else begin
        v[0]   <= in_val;
        lst[0] <= in_last;
        for (int i = 1; i < STAGES; i++) begin
          v[i]   <= v[i-1];
          lst[i] <= lst[i-1];
        end
      end
    end

    always_ff @(posedge clk) begin
      d[0] <= in_data;
      for (int i = 1; i < STAGES; i++) d[i] <= d[i-1];
    end

    assign out_val  = v[STAGES-1];
    assign out_last = lst[STAGES-1];
    assign out_data = d[STAGES-1];
  end
endmodule

// File: rtl/burst2_sram.sv
`timescale 1ns/1ps
module burst2_sram #(
  parameter int DW        = 36,
  parameter int LANES     = 4,
  parameter int AW        = 4,
  parameter int EXTRA_LAT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_sel_n,
  input  logic             wr_sel_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] wbe_n,
  output logic [DW-1:0]    rdata,
  output logic             rd_valid,
  output logic             rd_last
);
  import b2s_pkg::*;

  localparam int LW     = DW / LANES;
  localparam int STAGES = 2 * EXTRA_LAT;

  phase_e           ph;
  logic             fall;
  logic             rp, wp, rq_val, fwd;
  logic [AW-1:0]    raddr_q;
  logic [DW-1:0]    wd0, fd0, fd1;
  logic [LANES-1:0] wm0, fm0, fm1;
  logic [DW-1:0]    rq0, rq1, mrg0, mrg1;
  logic             s_val, s_last;
  logic [DW-1:0]    s_data;

  assign fall = (ph == PH_FALL);

  // Control state: phase, pending read/write, forwarding hit.
  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_RISE;
      rp     <= 1'b0;
      wp     <= 1'b0;
      rq_val <= 1'b0;
      fwd    <= 1'b0;
    end else if (!fall) begin
      ph <= PH_FALL;
      rp <= ~rd_sel_n;
      wp <= ~wr_sel_n;
    end else begin
      ph     <= PH_RISE;
      rq_val <= rp;
      fwd    <= rp && wp && (addr == raddr_q);
    end
  end

  // Captured address and data; no reset needed.
  always_ff @(posedge clk) begin
    if (!fall) begin
      if (!rd_sel_n) raddr_q <= addr;
      if (!wr_sel_n) begin
        wd0 <= wdata;
        wm0 <= ~wbe_n;
      end
    end else begin
      fd0 <= wd0;
      fm0 <= wm0;
      fd1 <= wdata;
      fm1 <= ~wbe_n;
    end
  end

  // Two banks, one per beat; both written and read on the second phase.
  logic [DW-1:0]    bwd [2];
  logic [LANES-1:0] bwm [2];
  logic [DW-1:0]    brd [2];

  assign bwd[0] = wd0;
  assign bwd[1] = wdata;
  assign bwm[0] = wm0;
  assign bwm[1] = ~wbe_n;
  assign rq0    = brd[0];
  assign rq1    = brd[1];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    b2s_bank #(.DW(DW), .LANES(LANES), .AW(AW)) u_bank (
      .clk   (clk),
      .we    (fall && wp),
      .waddr (addr),
      .wdata (bwd[b]),
      .wmask (bwm[b]),
      .re    (fall && rp),
      .raddr (raddr_q),
      .rdata (brd[b])
    );
  end

  // Lane-wise merge of forwarded write data over the array read.
  always_comb begin
    mrg0 = rq0;
    mrg1 = rq1;
    for (int l = 0; l < LANES; l++) begin
      if (fwd && fm0[l]) mrg0[l*LW +: LW] = fd0[l*LW +: LW];
      if (fwd && fm1[l]) mrg1[l*LW +: LW] = fd1[l*LW +: LW];
    end
  end

  // Beat serialiser: beat 0 on a first-phase edge, beat 1 on the next.
  always_ff @(posedge clk) begin
    if (rst) begin
      s_val  <= 1'b0;
      s_last <= 1'b0;
    end else begin
      s_val  <= rq_val;
      s_last <= fall;
    end
  end

  always_ff @(posedge clk) s_data <= fall ? mrg1 : mrg0;

  b2s_outpipe #(.DW(DW), .STAGES(STAGES)) u_outpipe (
    .clk      (clk),
    .rst      (rst),
    .in_val   (s_val),
    .in_last  (s_last),
    .in_data  (s_data),
    .out_val  (rd_valid),
    .out_last (rd_last),
    .out_data (rdata)
  );
endmodule

// File: rtl/b2s_check.sv
`timescale 1ns/1ps
module b2s_check #(
  parameter int EXTRA_LAT = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_sel_n,
  input b2s_pkg::phase_e  ph,
  input logic             rd_valid,
  input logic             rd_last
);
  localparam int LAT = 2 + 2 * EXTRA_LAT;

  logic [LAT:0] hist;

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[LAT-1:0], (ph == b2s_pkg::PH_RISE) && !rd_sel_n};
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !rd_valid); // R1
  AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_last) |=> (rd_valid && rd_last)); // R2
  AST_LAST_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_last) |-> $past(rd_valid && !rd_last)); // R2
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_last) |-> hist[LAT]); // R7
  AST_READ_PRODUCES: assert property (@(posedge clk) disable iff (rst)
    hist[LAT] |-> (rd_valid && !rd_last)); // R2
endmodule

bind burst2_sram b2s_check #(.EXTRA_LAT(EXTRA_LAT)) u_b2s_check (
  .clk      (clk),
  .rst      (rst),
  .rd_sel_n (rd_sel_n),
  .ph       (ph),
  .rd_valid (rd_valid),
  .rd_last  (rd_last)
);

// File: tb/test_burst2_sram.sv
`timescale 1ns/1ps
module test_burst2_sram;
  localparam int DW = 36, LANES = 4, AW = 4, EXTRA_LAT = 1;
  localparam int LW = DW / LANES;
  localparam int DEPTH = 1 << AW;
  localparam int LATC = 3 + 2 * EXTRA_LAT; // drive-time count to beat 0 (R2)

  typedef struct packed {
    logic          rd;
    logic [AW-1:0] ra;
    logic          wr;
    logic [AW-1:0] wa;
    logic [DW-1:0] d0;
    logic [LANES-1:0] m0;
    logic [DW-1:0] d1;
    logic [LANES-1:0] m1;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 4'd3,  1'b0, 4'd0,  36'h0,         4'h0, 36'h0,         4'h0},
    '{1'b0, 4'd0,  1'b1, 4'd5,  36'h123456789, 4'hF, 36'h9ABCDEF01, 4'hF},
    '{1'b1, 4'd5,  1'b0, 4'd0,  36'h0,         4'h0, 36'h0,         4'h0},
    '{1'b0, 4'd0,  1'b1, 4'd6,  36'hFFFFFFFFF, 4'h5, 36'hEEEEEEEEE, 4'hA},
    '{1'b1, 4'd6,  1'b0, 4'd0,  36'h0,         4'h0, 36'h0,         4'h0},
    '{1'b1, 4'd7,  1'b1, 4'd7,  36'h111111111, 4'hF, 36'h222222222, 4'hF},
    '{1'b1, 4'd8,  1'b1, 4'd8,  36'h333333333, 4'h3, 36'h444444444, 4'h8},
    '{1'b1, 4'd9,  1'b1, 4'd10, 36'h555555555, 4'hF, 36'h666666666, 4'hF},
    '{1'b1, 4'd10, 1'b0, 4'd0,  36'h0,         4'h0, 36'h0,         4'h0},
    '{1'b0, 4'd0,  1'b1, 4'd11, 36'h777777777, 4'h0, 36'h888888888, 4'h0},
    '{1'b1, 4'd11, 1'b0, 4'd0,  36'h0,         4'h0, 36'h0,         4'h0},
    '{1'b1, 4'd12, 1'b0, 4'd12, 36'hBADBADBAD, 4'hF, 36'hDEADDEAD0, 4'hF},
    '{1'b1, 4'd12, 1'b0, 4'd0,  36'h0,         4'h0, 36'h0,         4'h0},
    '{1'b0, 4'd4,  1'b0, 4'd4,  36'hCAFECAFE1, 4'hF, 36'hCAFECAFE2, 4'hF}
  };
  localparam string TAG [NV] = '{"R2", "R3", "R3", "R4", "R4", "R5", "R5",
                                 "R9", "R9", "R4", "R4", "R6", "R6", "R7"};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             rd_sel_n = 1'b1;
  logic             wr_sel_n = 1'b1;
  logic [AW-1:0]    addr = '0;
  logic [DW-1:0]    wdata = '0;
  logic [LANES-1:0] wbe_n = '1;
  logic [DW-1:0]    rdata;
  logic             rd_valid;
  logic             rd_last;

  burst2_sram #(.DW(DW), .LANES(LANES), .AW(AW), .EXTRA_LAT(EXTRA_LAT)) i_burst2_sram (
    .clk(clk), .rst(rst), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .addr(addr),
    .wdata(wdata), .wbe_n(wbe_n), .rdata(rdata), .rd_valid(rd_valid), .rd_last(rd_last)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nerr = 0;
  logic [DW-1:0] ref0 [DEPTH];
  logic [DW-1:0] ref1 [DEPTH];
  logic [DW-1:0] exp_d [512];
  logic          exp_l [512];
  int            exp_c [512];
  string         exp_r [512];
  int            wr_ptr = 0, rd_ptr = 0;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                          logic [LANES-1:0] en);
    logic [DW-1:0] r = old;
    for (int l = 0; l < LANES; l++) if (en[l]) r[l*LW +: LW] = nw[l*LW +: LW];
    return r;
  endfunction

  task automatic push(logic [DW-1:0] d, logic l, int c, string r);
    exp_d[wr_ptr] = d; exp_l[wr_ptr] = l; exp_c[wr_ptr] = c; exp_r[wr_ptr] = r;
    wr_ptr++;
  endtask

  // Called just after a falling edge that precedes a first-phase edge.
  task automatic access(logic rd, int ra, logic wr, int wa, logic [DW-1:0] d0,
                        logic [LANES-1:0] m0, logic [DW-1:0] d1,
                        logic [LANES-1:0] m1, string r);
    logic [DW-1:0] e0, e1;
    rd_sel_n = !rd; wr_sel_n = !wr; addr = AW'(ra); wdata = d0; wbe_n = ~m0;
    if (rd) begin
      e0 = ref0[ra]; e1 = ref1[ra];
      if (wr && wa == ra) begin e0 = merge(e0, d0, m0); e1 = merge(e1, d1, m1); end
      push(e0, 1'b0, cyc + LATC, r);
      push(e1, 1'b1, cyc + LATC + 1, r);
    end
    @(negedge clk);
    addr = AW'(wa); wdata = d1; wbe_n = ~m1;
    if (wr) begin ref0[wa] = merge(ref0[wa], d0, m0); ref1[wa] = merge(ref1[wa], d1, m1); end
    @(negedge clk);
    rd_sel_n = 1'b1; wr_sel_n = 1'b1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) access(1'b0, 0, 1'b0, 0, '0, '0, '0, '0, "R7");
  endtask

  task automatic chk(logic ok, string r, logic [DW-1:0] act, logic [DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  // Output monitor, sampling a quarter period after each rising edge.
  always begin
    @(posedge clk); #5;
    if (!rst && rd_valid) begin
      if (rd_ptr == wr_ptr) begin
        nchk++; nerr++;
        $display("FAIL R7: unexpected beat actual=%h last=%0d expected=no beat", rdata, rd_last);
      end else begin
        nchk++;
        if (rdata !== exp_d[rd_ptr] || rd_last !== exp_l[rd_ptr] || cyc != exp_c[rd_ptr]) begin
          nerr++;
          $display("FAIL %s: actual data=%h last=%0d cyc=%0d expected data=%h last=%0d cyc=%0d",
                   exp_r[rd_ptr], rdata, rd_last, cyc, exp_d[rd_ptr], exp_l[rd_ptr], exp_c[rd_ptr]);
        end
        rd_ptr++;
      end
    end
  end

  initial begin
    #(20 * 200000);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_valid === 1'b0, "R1", {35'b0, rd_valid}, '0); // reset state
    rst = 1'b0;

    for (int a = 0; a < DEPTH; a++)
      access(1'b0, 0, 1'b1, a, 36'(a) * 36'h001010101 + 36'h0C0000000, '1,
             36'(a) * 36'h000303030 + 36'h030000000, '1, "R3");

    // Vector table (R2..R7, R9; rows 5-8 are back-to-back reads for R8)
    for (int i = 0; i < NV; i++)
      access(TBL[i].rd, TBL[i].ra, TBL[i].wr, TBL[i].wa, TBL[i].d0, TBL[i].m0,
             TBL[i].d1, TBL[i].m1, TAG[i]);
    idle(4);

    // R8: streaming reads mixed with writes on every access
    for (int a = 0; a < DEPTH; a++)
      access(1'b1, a, 1'b1, (a + 3) % DEPTH, 36'(a) * 36'h111, '1, 36'(a) * 36'h222, 4'h6, "R8");
    idle(4);

    // R1: reset while a read is in flight suppresses its output
    access(1'b1, 5, 1'b0, 0, '0, '0, '0, '0, "R1");
    rst = 1'b1;
    @(negedge clk);
    wr_ptr = rd_ptr;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(rd_valid === 1'b0, "R1", {35'b0, rd_valid}, '0);
    end
    rst = 1'b0;

    // R9: phase alignment after reset release; R5 forward with write mask on beat 1 only
    access(1'b1, 2, 1'b1, 2, 36'h0ABCDEF12, 4'h0, 36'h0FEDCBA98, 4'h4, "R5");
    access(1'b1, 5, 1'b1, 9, 36'h135791357, '1, 36'h246802468, '1, "R9");
    access(1'b1, 9, 1'b0, 0, '0, '0, '0, '0, "R9");
    idle(5);

    chk(rd_ptr == wr_ptr, "R2", DW'(rd_ptr), DW'(wr_ptr)); // every expected beat appeared
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule